// File: doc/BRIEF.md
# Byte FIFO Register Front End

This block sits between a 32-bit register bus and the transfer engine of a byte-wide serial controller. It owns two byte queues of 64 entries each. Software fills the outbound queue and empties the inbound queue through data registers. The engine takes outbound bytes and delivers inbound bytes through simple push and pop handshakes. Software can flush either queue at any time, and it can read the occupancy of both queues from a single status word.

The block also holds the controller's configuration words: control, clock setup, burst length and transmit length. Their stored values are driven to the engine. An interrupt pair is included as well: a sticky event register and an enable mask. Event bits are set by engine pulses and cleared by writing ones. The interrupt line is raised whenever an enabled event bit is pending.

Top module: `serial_fifo_front`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, both queues are empty, `irq` is low, `tx_avail` is low and `rx_space` is high.
- R2: A bus write at offset 0x04 appends `bus_wdata[7:0]` to the outbound queue. The oldest byte is shown on `tx_byte` while `tx_avail` is high, and a `tx_take` cycle removes it, so bytes leave in the order they were written.
- R3: A cycle with `rx_put` high appends `rx_byte` to the inbound queue. A bus read at offset 0x00 returns the oldest inbound byte in bits 7:0, with bits 31:8 zero, and removes it in the same cycle.
- R4: The status word at offset 0x28 holds the inbound count in bits 6:0 and the outbound count in bits 22:16, and all its other bits are 0. A full queue reports 64.
- R5: A push to a full queue is dropped and leaves the count and the contents unchanged. A pop from an empty queue is dropped, and a read of the empty inbound queue returns 0. `rx_space` is low exactly when the inbound queue holds 64 bytes.
- R6: In the control word at offset 0x08, writing 1 to bit 8 empties the outbound queue and writing 1 to bit 9 empties the inbound queue. The flush takes effect on the second clock edge after the write and wins over a push on that edge. Bits 8 and 9 always read 0, and every other control bit reads back as written.
- R7: The interrupt enable (0x0C), clock setup (0x1C), burst length (0x20) and transmit length (0x24) registers read back as written. Control, clock setup, burst length and transmit length drive `ctrl_out`, `clk_cfg_out`, `burst_out` and `xmit_out`.
- R8: An `evt_set` bit sets the matching bit of the event register at 0x10, where bit 16 means transfer complete. Writing 1 to a bit clears it and writing 0 leaves it alone. If a set and a clear of the same bit fall in one cycle, the set wins.
- R9: `irq` is high exactly when some event bit and the same enable bit are both 1.
- R10: Reads of registers other than offset 0x00 have no side effect, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| tx_byte | output | 8 | Oldest outbound byte |
| tx_avail | output | 1 | Outbound queue not empty |
| tx_take | input | 1 | Engine removes the outbound byte |
| rx_byte | input | 8 | Inbound byte from the engine |
| rx_space | output | 1 | Inbound queue not full |
| rx_put | input | 1 | Engine appends `rx_byte` |
| evt_set | input | 32 | Event pulses into the interrupt register |
| ctrl_out | output | 32 | Stored control word |
| clk_cfg_out | output | 32 | Stored clock setup |
| burst_out | output | 32 | Stored burst length |
| xmit_out | output | 32 | Stored transmit length |

## Verification
The hardest states to reach are the queue boundaries: a queue holding exactly 64 bytes, a 65th push that must be dropped, and a flush that lands while the queue is full. The bench reaches them by streaming 65 bus writes into the outbound queue and 65 engine pushes into the inbound queue. It then checks the count field, the head byte and the full order of the bytes drained afterwards. It also drives an event pulse in the same cycle as a write-one-to-clear of that bit, to reach the set-over-clear tie.

// File: rtl/serial_fifo_front_pkg.sv
// Shared constants for the serial FIFO register front end.
// The offsets are byte addresses on a 6-bit register bus.
package serial_fifo_front_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_RXDATA = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_TXDATA = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_IEN    = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_ISTA   = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_CLKCFG = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_BURST  = 6'h20;
    localparam logic [ADDR_W-1:0] OFF_XMIT   = 6'h24;
    localparam logic [ADDR_W-1:0] OFF_LEVEL  = 6'h28;

    localparam int TXFLUSH_BIT = 8;
    localparam int RXFLUSH_BIT = 9;
    localparam int RXLVL_LSB   = 0;
    localparam int TXLVL_LSB   = 16;
endpackage

// File: rtl/byte_fifo.sv
// Circular byte queue with occupancy count.
// Assumes: DEPTH >= 2. A push when full or a pop when empty is dropped.
// A flush empties the queue and overrides any push or pop in the same cycle.
// rdata shows the head entry, or 0 when the queue is empty.
module byte_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rptr];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store an accepted byte (storage needs no reset)
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wptr] <= wdata;
    end

    // Move the pointers and the count
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= step(wptr);
            if (do_pop)  rptr <= step(rptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/irq_unit.sv
// Sticky event register with an enable mask.
// Assumes: evt pulses set bits; a write of 1 clears a bit; set beats clear.
// irq is the OR over all enabled pending bits.
module irq_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_we,
    input  logic         sta_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] evt,
    output logic [W-1:0] en_q,
    output logic [W-1:0] sta_q,
    output logic         irq
);
    logic [W-1:0] clr;

    assign clr = sta_we ? wdata : '0;

    // Enable mask storage
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= wdata;
    end

    // Pending events: set by pulses, cleared by writing 1
    always_ff @(posedge clk) begin
        if (!rst_n) sta_q <= '0;
        else        sta_q <= (sta_q & ~clr) | evt;
    end

    assign irq = |(sta_q & en_q);
endmodule

// File: rtl/serial_fifo_front.sv
// Register front end: address decode, config storage, two byte queues,
// flush strobes and the interrupt pair.
// Assumes: single-cycle bus strobes; bus_rdata is valid in the strobe cycle.
module serial_fifo_front
    import serial_fifo_front_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic [7:0]        tx_byte,
    output logic              tx_avail,
    input  logic              tx_take,
    input  logic [7:0]        rx_byte,
    output logic              rx_space,
    input  logic              rx_put,
    input  logic [DATA_W-1:0] evt_set,
    output logic [DATA_W-1:0] ctrl_out,
    output logic [DATA_W-1:0] clk_cfg_out,
    output logic [DATA_W-1:0] burst_out,
    output logic [DATA_W-1:0] xmit_out
);
    localparam logic [DATA_W-1:0] STROBE_MASK =
        (DATA_W'(1) << TXFLUSH_BIT) | (DATA_W'(1) << RXFLUSH_BIT);

    logic              wr_ctrl, tx_push, rx_pop;
    logic              tx_flush_q, rx_flush_q;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]        rx_head;
    logic [DATA_W-1:0] int_en, int_sta, level_word;

    assign wr_ctrl = bus_wr && (bus_addr == OFF_CTRL);
    assign tx_push = bus_wr && (bus_addr == OFF_TXDATA);
    assign rx_pop  = bus_rd && (bus_addr == OFF_RXDATA);

    // Configuration words; the flush bits are never stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_out    <= '0;
            clk_cfg_out <= '0;
            burst_out   <= '0;
            xmit_out    <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFF_CTRL:   ctrl_out    <= bus_wdata & ~STROBE_MASK;
                OFF_CLKCFG: clk_cfg_out <= bus_wdata;
                OFF_BURST:  burst_out   <= bus_wdata;
                OFF_XMIT:   xmit_out    <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Flush strobes: high for the one cycle after the control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_flush_q <= 1'b0;
            rx_flush_q <= 1'b0;
        end else begin
            tx_flush_q <= wr_ctrl && bus_wdata[TXFLUSH_BIT];
            rx_flush_q <= wr_ctrl && bus_wdata[RXFLUSH_BIT];
        end
    end

    byte_fifo #(.DW(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush_q),
        .push(tx_push), .wdata(bus_wdata[7:0]),
        .pop(tx_take), .rdata(tx_byte),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    byte_fifo #(.DW(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush_q),
        .push(rx_put), .wdata(rx_byte),
        .pop(rx_pop), .rdata(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    assign tx_avail = !tx_empty;
    assign rx_space = !rx_full;

    irq_unit #(.W(DATA_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .en_we(bus_wr && (bus_addr == OFF_IEN)),
        .sta_we(bus_wr && (bus_addr == OFF_ISTA)),
        .wdata(bus_wdata), .evt(evt_set),
        .en_q(int_en), .sta_q(int_sta), .irq(irq)
    );

    // Pack both occupancy counts into the level word
    always_comb begin
        level_word = '0;
        level_word[RXLVL_LSB +: CW] = rx_cnt;
        level_word[TXLVL_LSB +: CW] = tx_cnt;
    end

    // Read multiplexer
    always_comb begin
        case (bus_addr)
            OFF_RXDATA: bus_rdata = {24'd0, rx_head};
            OFF_CTRL:   bus_rdata = ctrl_out;
            OFF_IEN:    bus_rdata = int_en;
            OFF_ISTA:   bus_rdata = int_sta;
            OFF_CLKCFG: bus_rdata = clk_cfg_out;
            OFF_BURST:  bus_rdata = burst_out;
            OFF_XMIT:   bus_rdata = xmit_out;
            OFF_LEVEL:  bus_rdata = level_word;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/serial_fifo_front_chk.sv
// Assertion checker for serial_fifo_front, attached through bind.
module serial_fifo_front_chk
    import serial_fifo_front_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tx_avail,
    input logic              tx_take,
    input logic [DATA_W-1:0] evt_set,
    input logic [CW-1:0]     tx_cnt,
    input logic [CW-1:0]     rx_cnt,
    input logic [DATA_W-1:0] int_sta
);
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_avail && tx_take && !(bus_wr && bus_addr == OFF_TXDATA))
        |=> (tx_cnt == '0));

    // R6
    tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_CTRL && bus_wdata[TXFLUSH_BIT])
        |-> ##2 (tx_cnt == '0));

    // R6
    strobe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFF_CTRL)
        |-> (bus_rdata[RXFLUSH_BIT:TXFLUSH_BIT] == 2'b00));

    // R8
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_ISTA && bus_wdata[16] && !evt_set[16])
        |=> !int_sta[16]);

    // R8
    set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_set[16] |=> int_sta[16]);
endmodule

bind serial_fifo_front serial_fifo_front_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_avail(tx_avail), .tx_take(tx_take), .evt_set(evt_set),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .int_sta(int_sta)
);

// File: tb/serial_fifo_front_test.sv
`timescale 1ns/1ps
module serial_fifo_front_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [7:0]  tx_byte;
    logic        tx_avail;
    logic        tx_take = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_space;
    logic        rx_put = 1'b0;
    logic [31:0] evt_set = '0;
    logic [31:0] ctrl_out, clk_cfg_out, burst_out, xmit_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    serial_fifo_front uut (.*);

    // op 0 = write, 1 = read and compare; fields: op, req, addr, data, expected
    localparam int NV = 16;
    localparam logic [79:0] VEC [NV] = '{
        {4'd0, 4'd7, 8'h0C, 32'h0001_0000, 32'h0},
        {4'd1, 4'd7, 8'h0C, 32'h0,         32'h0001_0000},   // R7
        {4'd0, 4'd7, 8'h1C, 32'h0000_1234, 32'h0},
        {4'd1, 4'd7, 8'h1C, 32'h0,         32'h0000_1234},   // R7
        {4'd0, 4'd7, 8'h20, 32'h00AB_CDEF, 32'h0},
        {4'd1, 4'd7, 8'h20, 32'h0,         32'h00AB_CDEF},   // R7
        {4'd0, 4'd7, 8'h24, 32'h0000_0055, 32'h0},
        {4'd1, 4'd7, 8'h24, 32'h0,         32'h0000_0055},   // R7
        {4'd0, 4'd6, 8'h08, 32'h0000_0F0B, 32'h0},
        {4'd1, 4'd6, 8'h08, 32'h0,         32'h0000_0C0B},   // R6
        {4'd0, 4'd2, 8'h04, 32'h0000_11A5, 32'h0},
        {4'd0, 4'd2, 8'h04, 32'h0000_003C, 32'h0},
        {4'd1, 4'd4, 8'h28, 32'h0,         32'h0002_0000},   // R4
        {4'd1, 4'd5, 8'h00, 32'h0,         32'h0},           // R5
        {4'd1, 4'd10, 8'h30, 32'h0,        32'h0},           // R10
        {4'd1, 4'd4, 8'h28, 32'h0,         32'h0002_0000}    // R4, R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic take();
        @(negedge clk); tx_take = 1'b1;
        @(negedge clk); tx_take = 1'b0;
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); rx_byte = b; rx_put = 1'b1;
        @(negedge clk); rx_put = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", {30'd0, tx_avail, irq}, 32'h0);
        check("R1", {31'd0, rx_space}, 32'h1);
        rd_chk("R1", 6'h28, 32'h0);
        rd_chk("R1", 6'h08, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][79:76] == 4'd0) wr(VEC[i][69:64], VEC[i][63:32]);
            else rd_chk($sformatf("R%0d", VEC[i][75:72]), VEC[i][69:64], VEC[i][31:0]);
        end

        // R2: outbound order and engine handshake
        #1 check("R2", {24'd0, tx_byte}, 32'hA5);
        take();
        #1 check("R2", {24'd0, tx_byte}, 32'h3C);
        take();
        #1 check("R2", {31'd0, tx_avail}, 32'h0);
        take();   // R5: pop from empty
        rd_chk("R5", 6'h28, 32'h0);

        // R3: inbound bytes read in order, upper bits zero
        put(8'h11); put(8'h22);
        rd_chk("R3", 6'h00, 32'h11);
        rd_chk("R3", 6'h00, 32'h22);
        rd_chk("R5", 6'h00, 32'h0);

        // R4/R5: 65 writes to the outbound queue, last one dropped
        for (int i = 0; i < 65; i++) wr(6'h04, 32'(i + 8'h40));
        rd_chk("R4", 6'h28, 32'h0040_0000);
        #1 check("R5", {24'd0, tx_byte}, 32'h40);
        // R6: flush the full outbound queue
        wr(6'h08, 32'h0000_0100);
        idle(1);
        rd_chk("R6", 6'h28, 32'h0);
        #1 check("R6", {31'd0, tx_avail}, 32'h0);

        // R5: fill the inbound queue, extra byte dropped
        for (int i = 0; i < 64; i++) put(8'(i));
        #1 check("R5", {31'd0, rx_space}, 32'h0);
        put(8'hFF);
        rd_chk("R4", 6'h28, 32'h0000_0040);
        for (int i = 0; i < 64; i++) rd_chk("R3", 6'h00, 32'(i));
        rd_chk("R5", 6'h28, 32'h0);

        // R6: inbound flush, strobe bit reads 0
        put(8'h01); put(8'h02); put(8'h03);
        wr(6'h08, 32'h0000_0200);
        idle(1);
        rd_chk("R6", 6'h28, 32'h0);
        rd_chk("R6", 6'h08, 32'h0);

        // R8/R9: transfer-complete event with enable set
        @(negedge clk); evt_set = 32'h0001_0000;
        @(negedge clk); evt_set = '0;
        #1 check("R9", {31'd0, irq}, 32'h1);
        rd_chk("R8", 6'h10, 32'h0001_0000);
        wr(6'h10, 32'h0);
        rd_chk("R8", 6'h10, 32'h0001_0000);
        wr(6'h0C, 32'h0);
        #1 check("R9", {31'd0, irq}, 32'h0);
        wr(6'h0C, 32'h0001_0000);
        #1 check("R9", {31'd0, irq}, 32'h1);
        wr(6'h10, 32'h0001_0000);
        rd_chk("R8", 6'h10, 32'h0);
        #1 check("R9", {31'd0, irq}, 32'h0);
        // R8: set and clear in one cycle, set wins
        @(negedge clk);
        bus_addr = 6'h10; bus_wdata = 32'h0001_0000; bus_wr = 1'b1;
        evt_set = 32'h0001_0000;
        @(negedge clk);
        bus_wr = 1'b0; evt_set = '0;
        rd_chk("R8", 6'h10, 32'h0001_0000);
        // R7: outputs follow stored config
        check("R7", clk_cfg_out, 32'h0000_1234);
        check("R7", burst_out, 32'h00AB_CDEF);
        check("R7", xmit_out, 32'h0000_0055);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule